// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the dependence checker of a five-stage in-order pipeline (fetch, decode with register read, execute with address generation, memory access, writeback). It is purely combinational. It looks at the source register numbers of the instruction in execute and compares them with the destination numbers and write flags of the two older instructions in the memory and writeback stages. From that comparison it picks, for each ALU input, either the register-file operand or a bypassed value, so that a result that already exists further down the pipe is used without waiting for it to be written back.

It also compares the sources of the instruction in decode against a load that is currently in execute. A loaded value is not available in time for the next instruction's execute cycle. In that case the block holds the program counter and the fetch/decode register for one cycle and turns the next execute slot into a bubble. Only true read-after-write dependences are considered. A later instruction that overwrites a register an older one still reads, or two writes to one register, never stall. Register 0 never matches, and neither does a producer whose write flag is low.

Top module: `hz_fwd_unit`

## Requirements
- R1: Each operand select is 2 bits wide and is 2'b00 (register-file value) whenever neither the memory-stage nor the writeback-stage producer matches that operand's execute-stage source. The value 2'b11 is never produced.
- R2: When the memory-stage producer has its write flag set, a nonzero destination, and that destination equals the operand's execute-stage source, the select is 2'b10 (memory-stage ALU result).
- R3: When only the writeback-stage producer matches the operand's source (write flag set, nonzero destination, equal number), the select is 2'b01 (writeback value).
- R4: When both producers match the same source, the memory-stage (younger) value wins and the select is 2'b10.
- R5: A destination number of 0 never produces a bypass select and never produces a stall.
- R6: A producer whose write flag is deasserted never produces a bypass select or a stall.
- R7: A load in execute (load flag and write flag set, nonzero destination) whose destination equals a used source of the decode-stage instruction raises hold_pc, hold_ifid and bubble_idex together in the same cycle. The three are always equal.
- R8: A decode source whose use flag is low never causes a stall, even if its number equals the load's destination.
- R9: An execute-stage producer that is not a load never causes a stall, whatever the register numbers are.
- R10: The two operands are judged independently: operand A's select depends only on ex_rs_a and operand B's only on ex_rs_b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs_a | input | 5 | First source register of the decode-stage instruction |
| id_rs_b | input | 5 | Second source register of the decode-stage instruction |
| id_use_a | input | 1 | Decode-stage instruction reads its first source |
| id_use_b | input | 1 | Decode-stage instruction reads its second source |
| ex_rs_a | input | 5 | First source register of the execute-stage instruction |
| ex_rs_b | input | 5 | Second source register of the execute-stage instruction |
| ex_rd | input | 5 | Destination of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination of the writeback-stage instruction |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| fwd_sel_a | output | 2 | Bypass select for ALU input A (00 file, 10 memory stage, 01 writeback) |
| fwd_sel_b | output | 2 | Bypass select for ALU input B (same encoding) |
| hold_pc | output | 1 | Hold the program counter this cycle |
| hold_ifid | output | 1 | Hold the fetch/decode pipeline register this cycle |
| bubble_idex | output | 1 | Load a bubble into the decode/execute pipeline register |

## Verification
The block has no state, so a wrong internal comparison shows up at the selects or the stall outputs in the same cycle the stage fields are applied. Errors do not build up over time. A faulty zero-register or write-flag qualifier shows as a spurious 10 or 01 select or a spurious stall. A broken priority shows as 01 where 10 is due. A lost use-flag qualifier shows as a stall on an instruction that does not read the register. The stimulus keeps register numbers in a narrow range so that coincident matches across stages and operands are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SEL_FILE = 2'b00,
    SEL_WB   = 2'b01,
    SEL_MEM  = 2'b10
  } fwd_sel_e;

  function automatic logic dep_hit(input logic [4:0] src, input logic [4:0] dst,
                                   input logic wr);
    return wr && (dst != '0) && (dst == src);
  endfunction

  function automatic fwd_sel_e pick_src(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SEL_MEM;
    else if (wb_hit) return SEL_WB;
    else             return SEL_FILE;
  endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wr,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = wr && (dst != ZERO_REG) && (dst == src);
  end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
(
  input  logic     mem_hit,
  input  logic     wb_hit,
  output fwd_sel_e sel
);
  always_comb begin
    sel = pick_src(mem_hit, wb_hit);
  end
endmodule

// File: rtl/hz_load_guard.sv
module hz_load_guard #(
  parameter int NSRC = 2
) (
  input  logic            is_load,
  input  logic [NSRC-1:0] src_hit,
  input  logic [NSRC-1:0] src_used,
  output logic            stall
);
  always_comb begin
    stall = is_load && |(src_hit & src_used);
  end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs_a,
  input  logic [AW-1:0] id_rs_b,
  input  logic          id_use_a,
  input  logic          id_use_b,
  input  logic [AW-1:0] ex_rs_a,
  input  logic [AW-1:0] ex_rs_b,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic          hold_pc,
  output logic          hold_ifid,
  output logic          bubble_idex
);
  localparam int NSRC = 2;

  logic [AW-1:0] ex_src [NSRC];
  logic [AW-1:0] id_src [NSRC];
  logic [NSRC-1:0] id_used;
  logic [NSRC-1:0] mem_hit;
  logic [NSRC-1:0] wb_hit;
  logic [NSRC-1:0] load_hit;
  fwd_sel_e        sel [NSRC];
  logic            load_stall;

  assign ex_src[0] = ex_rs_a;
  assign ex_src[1] = ex_rs_b;
  assign id_src[0] = id_rs_a;
  assign id_src[1] = id_rs_b;
  assign id_used   = {id_use_b, id_use_a};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hz_match #(.AW(AW)) u_mem (.src(ex_src[i]), .dst(mem_rd), .wr(mem_we), .hit(mem_hit[i]));
    hz_match #(.AW(AW)) u_wb  (.src(ex_src[i]), .dst(wb_rd),  .wr(wb_we),  .hit(wb_hit[i]));
    hz_match #(.AW(AW)) u_ld  (.src(id_src[i]), .dst(ex_rd),  .wr(ex_we),  .hit(load_hit[i]));
    hz_fwd_pick u_pick (.mem_hit(mem_hit[i]), .wb_hit(wb_hit[i]), .sel(sel[i]));
  end

  hz_load_guard #(.NSRC(NSRC)) u_guard (
    .is_load (ex_is_load),
    .src_hit (load_hit),
    .src_used(id_used),
    .stall   (load_stall)
  );

  assign fwd_sel_a   = sel[0];
  assign fwd_sel_b   = sel[1];
  assign hold_pc     = load_stall;
  assign hold_ifid   = load_stall;
  assign bubble_idex = load_stall;
endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] id_rs_a,
  input logic [AW-1:0] id_rs_b,
  input logic          id_use_a,
  input logic          id_use_b,
  input logic [AW-1:0] ex_rs_a,
  input logic [AW-1:0] ex_rs_b,
  input logic [AW-1:0] ex_rd,
  input logic          ex_we,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_we,
  input logic [AW-1:0] wb_rd,
  input logic          wb_we,
  input logic [1:0]    fwd_sel_a,
  input logic [1:0]    fwd_sel_b,
  input logic          hold_pc,
  input logic          hold_ifid,
  input logic          bubble_idex,
  input logic          load_stall
);
  always_comb begin
    p_sel_legal_r1: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11);
    if (mem_we && mem_rd != '0 && mem_rd == ex_rs_a)
      p_mem_first_r4: assert (fwd_sel_a == 2'b10);
    if (mem_rd == '0 && wb_rd == '0)
      p_zero_quiet_r5: assert (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00);
    if (!mem_we && !wb_we)
      p_we_off_r6: assert (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00);
    p_stall_trio_r7: assert (hold_pc == hold_ifid && hold_ifid == bubble_idex
                             && bubble_idex == load_stall);
    if (!id_use_a && !id_use_b)
      p_unused_quiet_r8: assert (!hold_pc);
    if (!ex_is_load)
      p_no_load_quiet_r9: assert (!bubble_idex);
  end
endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/hz_fwd_unit_bench.sv
module hz_fwd_unit_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd;
  logic id_use_a, id_use_b, ex_we, ex_is_load, mem_we, wb_we;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic hold_pc, hold_ifid, bubble_idex;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  hz_fwd_unit #(.AW(AW)) u_hz_fwd_unit (.*);

  function automatic bit m(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic w);
    if (!w) return 1'b0;
    if (d == 0) return 1'b0;
    return s == d;
  endfunction

  function automatic logic [1:0] want_sel(input logic [AW-1:0] s);
    if (m(s, mem_rd, mem_we)) return 2'b10;
    if (m(s, wb_rd, wb_we))   return 2'b01;
    return 2'b00;
  endfunction

  function automatic bit want_stall();
    if (!ex_is_load) return 1'b0;
    return (id_use_a && m(id_rs_a, ex_rd, ex_we)) || (id_use_b && m(id_rs_b, ex_rd, ex_we));
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic apply_and_check(input string req);
    @(negedge clk);
    #1;
    chk({req, " sel_a"}, {2'b0, fwd_sel_a}, {2'b0, want_sel(ex_rs_a)});
    chk({req, " sel_b"}, {2'b0, fwd_sel_b}, {2'b0, want_sel(ex_rs_b)});
    chk({req, " stall R7"}, {1'b0, hold_pc, hold_ifid, bubble_idex},
        {1'b0, {3{want_stall()}}});
  endtask

  task automatic clear_all();
    {id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd} = '0;
    {id_use_a, id_use_b, ex_we, ex_is_load, mem_we, wb_we} = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1357);
    clear_all();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all fields idle -> selects 00, no stall (R1)
    apply_and_check("R1 idle");
    // R2 memory-stage bypass on operand A only (R10)
    ex_rs_a = 5'd3; ex_rs_b = 5'd4; mem_rd = 5'd3; mem_we = 1'b1;
    apply_and_check("R2 R10 mem A");
    // R3 writeback-only bypass on operand B
    clear_all(); ex_rs_b = 5'd7; wb_rd = 5'd7; wb_we = 1'b1;
    apply_and_check("R3 wb B");
    // R4 both stages match, memory stage wins
    clear_all(); ex_rs_a = 5'd9; ex_rs_b = 5'd9; mem_rd = 5'd9; wb_rd = 5'd9;
    mem_we = 1'b1; wb_we = 1'b1;
    apply_and_check("R4 priority");
    // R5 register 0 never matches
    clear_all(); mem_we = 1'b1; wb_we = 1'b1; ex_we = 1'b1; ex_is_load = 1'b1;
    id_use_a = 1'b1; id_use_b = 1'b1;
    apply_and_check("R5 zero reg");
    // R6 write flags low
    clear_all(); ex_rs_a = 5'd5; mem_rd = 5'd5; wb_rd = 5'd5;
    id_rs_a = 5'd5; ex_rd = 5'd5; ex_is_load = 1'b1; id_use_a = 1'b1;
    apply_and_check("R6 we off");
    // R7 load-use on operand B
    clear_all(); id_rs_b = 5'd12; id_use_b = 1'b1; ex_rd = 5'd12; ex_we = 1'b1;
    ex_is_load = 1'b1;
    apply_and_check("R7 load use");
    // R8 same but source unused
    id_use_b = 1'b0;
    apply_and_check("R8 unused src");
    // R9 non-load producer in execute
    id_use_b = 1'b1; ex_is_load = 1'b0;
    apply_and_check("R9 alu producer");
    // random mix, narrow register range for frequent matches
    for (int n = 0; n < 3000; n++) begin
      id_rs_a = 5'($urandom_range(0, 3)); id_rs_b = 5'($urandom_range(0, 3));
      ex_rs_a = 5'($urandom_range(0, 3)); ex_rs_b = 5'($urandom_range(0, 3));
      ex_rd   = 5'($urandom_range(0, 3)); mem_rd  = 5'($urandom_range(0, 3));
      wb_rd   = 5'($urandom_range(0, 3));
      {id_use_a, id_use_b, ex_we, ex_is_load, mem_we, wb_we} = 6'($urandom);
      apply_and_check("R1-mix R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule